// File: doc/BRIEF.md
# VBI Line Mode Scheduler

The scheduler picks, once per video line, the mode byte that a downstream data slicer uses on that line, and hands it over at a programmable pixel position. It counts lines from vertical sync and pixels from the falling edge of horizontal sync. When the pixel count reaches the programmed alignment, it drives the resolved mode onto `mode_o` and raises `mode_load_o` for one clock.

The mode is resolved from three things: a line window set by first and last line registers, one global mode byte that covers every line in that window, and a per-line override table. A table entry other than 0xFF takes priority over the global mode on its line. Lines outside the window, and all lines when the window is empty, get 0xFF, which means no processing. The mode byte passes through without being decoded.

Top module: `vbi_line_sched`

## Requirements
- R1: After reset, `mode_o` is 0xFF and `mode_load_o` is 0. The alignment is 0x01E, the first window line is 0x06, the last window line is 0x1B, the global mode is 0xFF, and every table entry is 0xFF.
- R2: Register writes use `cfg_addr_i` as follows. 0 writes alignment bits [7:0]. 1 writes alignment bits [9:8] from `cfg_wdata_i[1:0]`, and bits [7:2] of that byte are ignored. 2 writes the first window line. 3 writes the last window line. 4 writes the global mode.
- R3: A horizontal sync falling edge is the first rising clock edge that samples `hsync_i` low after it was sampled high. `mode_load_o` is high in the cycle after rising edge number align+1 counted from that edge.
- R4: A line is processed only if first <= line <= last. Any other line receives mode 0xFF. If first > last, every line receives 0xFF.
- R5: The line number becomes 1 on a clock edge that samples `vsync_i` rising. It increases by one on each horizontal sync falling edge.
- R6: A processed line whose table entry is 0xFF, or whose number is beyond the table, receives the global mode.
- R7: A processed line whose table entry is not 0xFF receives that entry, whatever the global mode holds.
- R8: `mode_o` changes only together with `mode_load_o`. An alignment write is adopted at the next horizontal sync falling edge. Window, global and table writes are used at the next switch point.
- R9: At most one `mode_load_o` pulse follows each horizontal sync falling edge. A repeated falling edge restarts the pixel count. An alignment the line never reaches produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync level |
| vsync_i | input | 1 | Vertical sync level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | 8 | Register write data |
| tbl_we_i | input | 1 | Per-line table write strobe |
| tbl_addr_i | input | TBL_AW | Table line index |
| tbl_wdata_i | input | 8 | Table entry, 0xFF means not set |
| mode_o | output | 8 | Current line mode |
| mode_load_o | output | 1 | One-cycle mode load strobe |

## Verification
For each line, the driver notes the cycle in which it drops `hsync_i`. It then expects `mode_load_o` and the new `mode_o` align+2 cycles later, counted on the falling clock edge used for sampling. That delay is one edge to sample the sync, align edges of pixel counting, and one output register. The expected cycle and mode are pushed into a queue. The monitor pops an entry only when a pulse appears and compares both the cycle and the byte. In every cycle without a pulse it confirms that `mode_o` has held its value. Register writes are placed between lines, so each one falls at a known adoption point.

// File: rtl/vbi_sched_pkg.sv
package vbi_sched_pkg;
  localparam int PIX_W  = 10;
  localparam int MODE_W = 8;
  localparam logic [MODE_W-1:0] MODE_IDLE = 8'hFF;

  typedef enum logic [2:0] {
    SEL_ALIGN_LO = 3'd0,
    SEL_ALIGN_HI = 3'd1,
    SEL_FIRST    = 3'd2,
    SEL_LAST     = 3'd3,
    SEL_GLOBAL   = 3'd4
  } cfg_sel_e;

  typedef struct packed {
    logic [PIX_W-1:0]  align;
    logic [MODE_W-1:0] first_line;
    logic [MODE_W-1:0] last_line;
    logic [MODE_W-1:0] global_mode;
  } sched_cfg_t;
endpackage

// File: rtl/vbi_cfg_regs.sv
module vbi_cfg_regs
  import vbi_sched_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [MODE_W-1:0] wdata_i,
  output sched_cfg_t        cfg_o
);
  localparam int HI_W = PIX_W - 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.align       <= PIX_W'(10'h01E);
      cfg_o.first_line  <= 8'h06;
      cfg_o.last_line   <= 8'h1B;
      cfg_o.global_mode <= MODE_IDLE;
    end else if (we_i) begin
      unique case (cfg_sel_e'(addr_i))
        SEL_ALIGN_LO: cfg_o.align[7:0]       <= wdata_i;
        SEL_ALIGN_HI: cfg_o.align[PIX_W-1:8] <= wdata_i[HI_W-1:0]; // upper bits reserved
        SEL_FIRST:    cfg_o.first_line       <= wdata_i;
        SEL_LAST:     cfg_o.last_line        <= wdata_i;
        SEL_GLOBAL:   cfg_o.global_mode      <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vbi_line_timer.sv
module vbi_line_timer
  import vbi_sched_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [PIX_W-1:0]  align_i,
  output logic [LINE_W-1:0] line_o,
  output logic              switch_o
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic             hs_q, vs_q, hs_fall, vs_rise, armed;
  logic [PIX_W-1:0] pix_cnt, align_act;

  assign hs_fall  = hs_q & ~hsync_i;
  assign vs_rise  = vsync_i & ~vs_q;
  assign switch_o = armed && (pix_cnt == align_act);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q      <= 1'b0;
      vs_q      <= 1'b0;
      pix_cnt   <= '0;
      align_act <= PIX_W'(10'h01E);
      armed     <= 1'b0;
      line_o    <= '0;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
      if (hs_fall) begin
        pix_cnt   <= '0;
        align_act <= align_i;
        armed     <= 1'b1;
      end else begin
        if (pix_cnt != PIX_MAX) pix_cnt <= pix_cnt + 1'b1;
        if (switch_o) armed <= 1'b0;
      end
      if (vs_rise)                          line_o <= LINE_W'(1);
      else if (hs_fall && line_o != LINE_MAX) line_o <= line_o + 1'b1;
    end
  end

  AST_PIX_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_fall |=> pix_cnt == '0); // R3
  AST_ALIGN_ADOPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_fall |=> align_act == $past(align_i)); // R8
  AST_LINE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_i) |=> line_o == LINE_W'(1)); // R5
endmodule

// File: rtl/vbi_mode_resolve.sv
module vbi_mode_resolve
  import vbi_sched_pkg::*;
#(
  parameter int TBL_DEPTH = 32,
  parameter int LINE_W    = 10,
  localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [TBL_AW-1:0] tbl_addr_i,
  input  logic [MODE_W-1:0] tbl_wdata_i,
  input  logic [LINE_W-1:0] line_i,
  input  sched_cfg_t        cfg_i,
  output logic [MODE_W-1:0] mode_next_o
);
  logic [MODE_W-1:0] entry_q [TBL_DEPTH];
  logic [MODE_W-1:0] entry_sel;
  logic              in_tbl, in_win;

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     entry_q[g] <= MODE_IDLE;
      else if (tbl_we_i && tbl_addr_i == TBL_AW'(g)) entry_q[g] <= tbl_wdata_i;
    end
  end

  assign in_tbl    = line_i < LINE_W'(TBL_DEPTH);
  assign entry_sel = in_tbl ? entry_q[line_i[TBL_AW-1:0]] : MODE_IDLE;
  assign in_win    = (line_i >= LINE_W'(cfg_i.first_line)) &&
                     (line_i <= LINE_W'(cfg_i.last_line));

  always_comb begin
    if (!in_win)                     mode_next_o = MODE_IDLE;
    else if (entry_sel != MODE_IDLE) mode_next_o = entry_sel;
    else                             mode_next_o = cfg_i.global_mode;
  end

  AST_EMPTY_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.first_line > cfg_i.last_line) |-> mode_next_o == MODE_IDLE); // R4
endmodule

// File: rtl/vbi_line_sched.sv
module vbi_line_sched
  import vbi_sched_pkg::*;
#(
  parameter int TBL_DEPTH = 32,
  parameter int LINE_W    = 10,
  localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              tbl_we_i,
  input  logic [TBL_AW-1:0] tbl_addr_i,
  input  logic [7:0]        tbl_wdata_i,
  output logic [7:0]        mode_o,
  output logic              mode_load_o
);
  sched_cfg_t        cfg;
  logic [LINE_W-1:0] line;
  logic              switch_now;
  logic [MODE_W-1:0] mode_next;

  vbi_cfg_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg)
  );

  vbi_line_timer #(.LINE_W(LINE_W)) u_timer (
    .clk_i, .rst_ni, .hsync_i, .vsync_i,
    .align_i(cfg.align), .line_o(line), .switch_o(switch_now)
  );

  vbi_mode_resolve #(.TBL_DEPTH(TBL_DEPTH), .LINE_W(LINE_W)) u_resolve (
    .clk_i, .rst_ni, .tbl_we_i, .tbl_addr_i, .tbl_wdata_i,
    .line_i(line), .cfg_i(cfg), .mode_next_o(mode_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= MODE_IDLE;
      mode_load_o <= 1'b0;
    end else begin
      mode_load_o <= switch_now;
      if (switch_now) mode_o <= mode_next;
    end
  end

  AST_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_load_o |=> !mode_load_o); // R9
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_load_o |-> $stable(mode_o)); // R8
endmodule

// File: tb/tb_vbi_line_sched.sv
module tb_vbi_line_sched;
  localparam int CLK_PERIOD = 10;
  localparam int HIGH_LEN   = 4;
  localparam int LOW_LEN    = 296;
  localparam int DEPTH      = 32;

  logic clk = 0, rst_ni = 0;
  logic hsync_i = 0, vsync_i = 0;
  logic cfg_we_i = 0, tbl_we_i = 0;
  logic [2:0] cfg_addr_i = 0;
  logic [7:0] cfg_wdata_i = 0, tbl_wdata_i = 0;
  logic [4:0] tbl_addr_i = 0;
  logic [7:0] mode_o;
  logic       mode_load_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbi_line_sched dut (.clk_i(clk), .rst_ni, .hsync_i, .vsync_i, .cfg_we_i,
    .cfg_addr_i, .cfg_wdata_i, .tbl_we_i, .tbl_addr_i, .tbl_wdata_i,
    .mode_o, .mode_load_o);

  int cyc = 0;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // model state
  int         m_line = 0;
  int         m_align = 30, m_first = 6, m_last = 27;
  logic [7:0] m_global = 8'hFF;
  logic [7:0] m_tbl [DEPTH];
  int         q_due[$];
  logic [7:0] q_mode[$];
  logic [7:0] exp_mode = 8'hFF;

  function automatic logic [7:0] expect_mode(int line);
    logic [7:0] e;
    if (line < m_first || line > m_last) return 8'hFF;
    e = (line < DEPTH) ? m_tbl[line] : 8'hFF;
    return (e != 8'hFF) ? e : m_global;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk); cfg_we_i = 0;
    case (a)
      3'd0: m_align = (m_align & 'h300) | d;
      3'd1: m_align = (m_align & 'hFF) | (int'(d[1:0]) << 8);
      3'd2: m_first = d;
      3'd3: m_last  = d;
      3'd4: m_global = d;
      default: ;
    endcase
  endtask

  task automatic wr_tbl(input int a, input logic [7:0] d);
    @(negedge clk); tbl_we_i = 1; tbl_addr_i = 5'(a); tbl_wdata_i = d;
    @(negedge clk); tbl_we_i = 0;
    m_tbl[a] = d;
  endtask

  task automatic do_vsync();
    @(negedge clk); vsync_i = 1;
    repeat (2) @(negedge clk);
    vsync_i = 0;
    m_line = 1;
  endtask

  // one line; glitch adds a second falling edge shortly after the first
  task automatic drive_line(input bit glitch);
    int c;
    @(negedge clk); hsync_i = 1;
    repeat (HIGH_LEN - 1) @(negedge clk);
    hsync_i = 0; m_line++;
    if (glitch) begin
      repeat (2) @(negedge clk); hsync_i = 1;
      repeat (2) @(negedge clk); hsync_i = 0; m_line++;
    end
    c = cyc;
    if (m_align + 2 < LOW_LEN) begin
      q_due.push_back(c + m_align + 2);
      q_mode.push_back(expect_mode(m_line));
    end
    repeat (LOW_LEN - (glitch ? 4 : 0)) @(negedge clk);
  endtask

  // monitor: pops expectations as pulses appear
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (mode_load_o) begin
        if (q_due.size() == 0) begin
          chk(0, "R9 unexpected pulse", cyc, -1);
        end else begin
          int due; logic [7:0] m;
          due = q_due.pop_front(); m = q_mode.pop_front();
          chk(cyc == due, "R3 pulse cycle", cyc, due);
          chk(mode_o == m, "R4/R6/R7 mode", mode_o, m);
          exp_mode = m;
        end
      end else begin
        chk(mode_o == exp_mode, "R8 mode hold", mode_o, exp_mode);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_tbl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(mode_o == 8'hFF, "R1 reset mode", mode_o, 8'hFF);
    chk(mode_load_o == 0, "R1 reset load", mode_load_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk(mode_o == 8'hFF, "R1 idle after reset", mode_o, 8'hFF);

    // R2 R6 R7: global plus overrides; default window and alignment (R1)
    wr_cfg(3'd4, 8'h5A);
    wr_tbl(8, 8'h33);
    wr_tbl(27, 8'h44);
    wr_tbl(3, 8'h11);   // outside window: R4
    wr_tbl(6, 8'hFF);
    do_vsync();         // R5
    for (int i = 0; i < 30; i++) drive_line(0);

    // R2: 10-bit alignment, reserved high bits set
    wr_cfg(3'd0, 8'h01);
    wr_cfg(3'd1, 8'hFD);
    do_vsync();
    for (int i = 0; i < 10; i++) drive_line(0);

    // R4: narrowed window, then empty window
    wr_cfg(3'd0, 8'h10); wr_cfg(3'd1, 8'h00);
    wr_cfg(3'd2, 8'h04); wr_cfg(3'd3, 8'h09);
    do_vsync();
    for (int i = 0; i < 12; i++) drive_line(0);
    wr_cfg(3'd2, 8'h0A); wr_cfg(3'd3, 8'h05);
    do_vsync();
    for (int i = 0; i < 12; i++) drive_line(0);

    // R8: global change between lines, used at next switch
    wr_cfg(3'd2, 8'h02); wr_cfg(3'd3, 8'h30);
    do_vsync();
    drive_line(0); drive_line(0);
    wr_cfg(3'd4, 8'hC3);
    drive_line(0); drive_line(0);

    // R9: unreachable alignment, then glitched sync
    wr_cfg(3'd0, 8'hFF); wr_cfg(3'd1, 8'h03);
    drive_line(0);
    wr_cfg(3'd0, 8'h14); wr_cfg(3'd1, 8'h00);
    drive_line(0);
    drive_line(1);
    drive_line(0);

    repeat (10) @(negedge clk);
    chk(q_due.size() == 0, "R3 missing pulses", q_due.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule